// File: doc/BRIEF.md
# PCIe Receive Payload Realigner

This block sits behind the receive side of a PCI Express transaction layer. It takes the packets from a 128-bit streaming bus. Each beat of that bus carries four 32-bit lanes and is framed by valid, start, end and empty flags. The block splits off the 3- or 4-dword header and presents it on a header port. It then repacks the payload so that payload dword 0 always sits in lane 0 of the first output beat, and dword k of the packet sits in lane k mod 4.

Where the first payload dword lands on the input depends on two things: the header length and address bit 2. Depending on them, it can arrive in the start beat, or it can follow a pad lane in the next beat. The block finds and drops that pad. It holds up to three dwords in a carry register across beat boundaries. When the packet ends with dwords still held, it emits one more beat.

The output uses a valid/ready handshake and carries a dword count and an end flag. The input is stalled with a ready signal whenever the output cannot move, or while a final flush beat is pending.

Top module: `tlp_rx_realign`

## Requirements
- R1: The header is decoded from lane 0 of the start beat. Bit 29 set means a 4-dword header. Bit 30 set means the packet carries payload. Bits [9:0] give the payload length in dwords, with 0 meaning 1024. Address bit 2 is bit 2 of lane 2 for a 3-dword header and bit 2 of lane 3 for a 4-dword header. `hdr_4dw_o` reports the header size.
- R2: One cycle after a start beat is accepted, `hdr_valid_o` pulses for one cycle and `hdr_o` holds lanes 0..3 of that beat. For a 3-dword header, lane 3 of `hdr_o` is forced to zero.
- R3: For a 3-dword header with address bit 2 set, payload dword 0 is taken from lane 3 of the start beat. With address bit 2 clear, that lane is a pad and payload starts in lane 0 of the next beat.
- R4: For a 4-dword header, the start beat carries no payload. In the next beat, payload starts in lane 0 when address bit 2 is clear. When it is set, payload starts in lane 1 and lane 0 is dropped as a pad.
- R5: Payload ends after exactly the header length. Any lanes past it in the final input beat are discarded, whether the empty flag marks them invalid or not. Empty marks lanes 2 and 3 of an end beat as invalid.
- R6: Every output beat has `out_cnt_o` between 1 and 4. Every beat except the last of a packet carries 4 dwords. Dwords come out in order, packed from lane 0.
- R7: `out_last_o` marks the final payload beat of each packet. If dwords remain held in the carry register when the input packet ends, they are emitted as one extra final beat.
- R8: A packet without payload produces only the header pulse and no payload beat.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output beat is held unchanged and `in_ready_o` is low. No dword is lost or duplicated under any stall pattern.
- R10: During reset, `out_valid_o` and `hdr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| in_data_i | input | 128 | Four dword lanes, lane 0 in bits [31:0] |
| in_sop_i | input | 1 | First beat of a packet |
| in_eop_i | input | 1 | Last beat of a packet |
| in_empty_i | input | 1 | On an end beat, only lanes 0 and 1 are valid |
| hdr_valid_o | output | 1 | One-cycle header pulse |
| hdr_o | output | 128 | Header dwords, dword 0 in bits [31:0] |
| hdr_4dw_o | output | 1 | Header is 4 dwords |
| out_valid_o | output | 1 | Output payload beat valid |
| out_ready_i | input | 1 | Downstream accepts the output beat |
| out_data_o | output | 128 | Realigned payload, lane 0 first |
| out_cnt_o | output | 3 | Valid dwords in the beat, 1 to 4 |
| out_last_o | output | 1 | Final payload beat of the packet |

## Verification
The sweep covers both header sizes, both address phases, and payload lengths 1 to 12, plus a packet with length field 0. Together these land the packet end at every lane offset, both with and without a carry to flush. A design that starts at the wrong lane, or keeps a pad dword, shows a shifted dword in lane 0. A design that drops the flush beat leaves dwords missing. A design that takes the garbage lanes of the final beat reports too high a count on its last beat.

Payload-free packets are mixed in; a design that emits a beat for them produces an unexpected payload beat. Three stall patterns, among them pseudo-random stalls on both sides, expose any beat that changes while held. They also expose a dword lost or repeated at a stalled boundary.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;
  localparam int DW_W    = 32;
  localparam int LANES   = 4;
  localparam int BUS_W   = DW_W * LANES;
  localparam int LEN_W   = 10;
  localparam int RLEN_W  = LEN_W + 1;
  localparam int CNT_W   = $clog2(LANES + 1);
  localparam int LIDX_W  = $clog2(LANES);
  localparam int CARRY_W = (LANES - 1) * DW_W;
  localparam int MERGE_W = (2 * LANES - 1) * DW_W;

  // header dword 0 field positions
  localparam int FMT_4DW_BIT  = 29;
  localparam int FMT_DATA_BIT = 30;
  localparam int ADDR2_BIT    = 2;

  typedef struct packed {
    logic              four_dw;
    logic              has_data;
    logic              addr2;
    logic [RLEN_W-1:0] len;
  } hdr_info_t;
endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
  import tlp_rx_pkg::*;
(
  input  logic [BUS_W-1:0] beat_i,
  output hdr_info_t        info_o
);
  logic [DW_W-1:0] dw0, dw2, dw3;
  logic            is4;

  assign dw0 = beat_i[0 +: DW_W];
  assign dw2 = beat_i[2*DW_W +: DW_W];
  assign dw3 = beat_i[3*DW_W +: DW_W];
  assign is4 = dw0[FMT_4DW_BIT];

  always_comb begin
    info_o.four_dw  = is4;
    info_o.has_data = dw0[FMT_DATA_BIT];
    info_o.addr2    = is4 ? dw3[ADDR2_BIT] : dw2[ADDR2_BIT];
    info_o.len      = (dw0[LEN_W-1:0] == '0) ? RLEN_W'(1 << LEN_W)
                                             : {1'b0, dw0[LEN_W-1:0]};
  end
endmodule

// File: rtl/tlp_lane_extract.sv
module tlp_lane_extract
  import tlp_rx_pkg::*;
(
  input  logic [BUS_W-1:0]  beat_i,
  input  logic [LIDX_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  take_i,
  output logic [BUS_W-1:0]  dw_o
);
  logic [BUS_W-1:0] shifted;

  assign shifted = beat_i >> (skip_i * DW_W);

  // zero lanes past take so the merge sees clean upper lanes
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dw_o[l*DW_W +: DW_W] = (CNT_W'(l) < take_i) ? shifted[l*DW_W +: DW_W] : '0;
  end
endmodule

// File: rtl/tlp_carry_merge.sv
module tlp_carry_merge
  import tlp_rx_pkg::*;
(
  input  logic [CARRY_W-1:0] carry_i,
  input  logic [CNT_W-1:0]   carry_cnt_i,
  input  logic [BUS_W-1:0]   new_i,
  input  logic [CNT_W-1:0]   take_i,
  output logic [MERGE_W-1:0] merged_o,
  output logic [CNT_W-1:0]   total_o
);
  assign merged_o = ({{(MERGE_W-BUS_W){1'b0}}, new_i} << (carry_cnt_i * DW_W))
                  | {{(MERGE_W-CARRY_W){1'b0}}, carry_i};
  assign total_o  = carry_cnt_i + take_i;
endmodule

// File: rtl/tlp_rx_realign.sv
module tlp_rx_realign
  import tlp_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [BUS_W-1:0] in_data_i,
  input  logic             in_sop_i,
  input  logic             in_eop_i,
  input  logic             in_empty_i,
  output logic             hdr_valid_o,
  output logic [BUS_W-1:0] hdr_o,
  output logic             hdr_4dw_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [BUS_W-1:0] out_data_o,
  output logic [CNT_W-1:0] out_cnt_o,
  output logic             out_last_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LANES);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(LANES / 2);

  hdr_info_t          hinfo;
  logic               has_data_q, addr2_q, post4_q, flush_q;
  logic [RLEN_W-1:0]  rem_q, rem_in, rem_nxt;
  logic [CARRY_W-1:0] carry_q;
  logic [CNT_W-1:0]   carry_cnt_q;

  logic               out_free, acc, cur_data, fin;
  logic [CNT_W-1:0]   lanes_here, avail, take, tot;
  logic [LIDX_W-1:0]  skip;
  logic [BUS_W-1:0]   new_dw;
  logic [MERGE_W-1:0] merged;
  logic               emit_full, emit_tail, flush_set;

  tlp_hdr_decode u_dec (
    .beat_i (in_data_i),
    .info_o (hinfo)
  );

  assign out_free   = !out_valid_o || out_ready_i;
  assign in_ready_o = out_free && !flush_q;
  assign acc        = in_valid_i && in_ready_o;

  assign cur_data   = in_sop_i ? hinfo.has_data : has_data_q;
  assign rem_in     = in_sop_i ? hinfo.len : rem_q;
  assign lanes_here = (in_eop_i && in_empty_i) ? HALF_CNT : FULL_CNT;

  // lane offset of first payload dword in this beat, and lanes usable
  always_comb begin
    skip  = '0;
    avail = lanes_here;
    if (in_sop_i) begin
      avail = '0;
      if (!hinfo.four_dw && hinfo.addr2) begin
        skip  = LIDX_W'(LANES - 1);
        avail = CNT_W'(1);
      end
    end else if (post4_q && addr2_q) begin
      skip  = LIDX_W'(1);
      avail = lanes_here - CNT_W'(1);
    end
  end

  always_comb begin
    if (!cur_data)                     take = '0;
    else if (RLEN_W'(avail) < rem_in)  take = avail;
    else                               take = rem_in[CNT_W-1:0];
  end

  assign rem_nxt = rem_in - RLEN_W'(take);
  assign fin     = cur_data && (rem_nxt == '0);

  tlp_lane_extract u_ext (
    .beat_i (in_data_i),
    .skip_i (skip),
    .take_i (take),
    .dw_o   (new_dw)
  );

  tlp_carry_merge u_mrg (
    .carry_i     (carry_q),
    .carry_cnt_i (carry_cnt_q),
    .new_i       (new_dw),
    .take_i      (take),
    .merged_o    (merged),
    .total_o     (tot)
  );

  assign emit_full = (tot >= FULL_CNT);
  assign emit_tail = fin && !emit_full && (tot != '0);
  assign flush_set = fin && (tot > FULL_CNT);

  // packet context
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_data_q <= 1'b0;
      addr2_q    <= 1'b0;
      post4_q    <= 1'b0;
      rem_q      <= '0;
    end else if (acc) begin
      if (in_sop_i) begin
        has_data_q <= hinfo.has_data;
        addr2_q    <= hinfo.addr2;
      end
      post4_q <= in_sop_i && hinfo.four_dw && hinfo.has_data && !in_eop_i;
      rem_q   <= rem_nxt;
    end
  end

  // header port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_valid_o <= 1'b0;
      hdr_o       <= '0;
      hdr_4dw_o   <= 1'b0;
    end else begin
      hdr_valid_o <= acc && in_sop_i;
      if (acc && in_sop_i) begin
        hdr_4dw_o <= hinfo.four_dw;
        hdr_o     <= hinfo.four_dw ? in_data_i
                                   : {{DW_W{1'b0}}, in_data_i[BUS_W-DW_W-1:0]};
      end
    end
  end

  // carry register and output stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q     <= '0;
      carry_cnt_q <= '0;
      flush_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_cnt_o   <= '0;
      out_last_o  <= 1'b0;
    end else if (acc) begin
      out_valid_o <= emit_full || emit_tail;
      if (emit_full || emit_tail) begin
        out_data_o <= merged[BUS_W-1:0];
        out_cnt_o  <= emit_full ? FULL_CNT : tot;
        out_last_o <= fin && !flush_set;
      end
      if (emit_full) begin
        carry_q     <= merged[MERGE_W-1:BUS_W];
        carry_cnt_q <= tot - FULL_CNT;
        flush_q     <= flush_set;
      end else if (emit_tail) begin
        carry_q     <= '0;
        carry_cnt_q <= '0;
      end else begin
        carry_q     <= merged[CARRY_W-1:0];
        carry_cnt_q <= tot;
      end
    end else if (flush_q && out_free) begin
      out_valid_o <= 1'b1;
      out_data_o  <= {{(BUS_W-CARRY_W){1'b0}}, carry_q};
      out_cnt_o   <= carry_cnt_q;
      out_last_o  <= 1'b1;
      carry_q     <= '0;
      carry_cnt_q <= '0;
      flush_q     <= 1'b0;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tlp_rx_realign_chk.sv
module tlp_rx_realign_chk
  import tlp_rx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             in_sop_i,
  input logic             hdr_valid_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [BUS_W-1:0] out_data_o,
  input logic [CNT_W-1:0] out_cnt_o,
  input logic             out_last_o
);
  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_cnt_o != '0) && (out_cnt_o <= CNT_W'(LANES)));

  assert_full_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> (out_cnt_o == CNT_W'(LANES)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o)
                                      && $stable(out_cnt_o) && $stable(out_last_o));

  assert_stall_in_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_hdr_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> $past(in_valid_i && in_ready_o && in_sop_i));
endmodule

bind tlp_rx_realign tlp_rx_realign_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_sop_i    (in_sop_i),
  .hdr_valid_o (hdr_valid_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_cnt_o   (out_cnt_o),
  .out_last_o  (out_last_o)
);

// File: tb/tlp_rx_realign_tb.sv
`timescale 1ns/1ps
module tlp_rx_realign_tb;
  import tlp_rx_pkg::*;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [BUS_W-1:0] in_data_i = '0;
  logic             in_sop_i = 1'b0;
  logic             in_eop_i = 1'b0;
  logic             in_empty_i = 1'b0;
  logic             hdr_valid_o;
  logic [BUS_W-1:0] hdr_o;
  logic             hdr_4dw_o;
  logic             out_valid_o;
  logic             out_ready_i = 1'b0;
  logic [BUS_W-1:0] out_data_o;
  logic [CNT_W-1:0] out_cnt_o;
  logic             out_last_o;

  always #4 clk_i = ~clk_i;

  tlp_rx_realign u_dut (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_data_i, .in_sop_i, .in_eop_i,
    .in_empty_i, .hdr_valid_o, .hdr_o, .hdr_4dw_o, .out_valid_o, .out_ready_i,
    .out_data_o, .out_cnt_o, .out_last_o
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [127:0] bq_data[$];
  bit           bq_sop[$], bq_eop[$], bq_empty[$];
  logic [31:0]  exp_dw[$];
  bit           exp_last[$];
  string        exp_tag[$];
  logic [128:0] exp_hdr[$];
  bit           exp_hdr_dat[$];

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic add_pkt(bit is4, bit a2, bit dat, int len, int id);
    logic [31:0] h[4];
    logic [31:0] pay[$];
    logic [31:0] st[$];
    logic [127:0] b;
    int start, idx, n;
    h[0] = {1'b0, dat, is4, 5'b0, 14'b0, 10'(len % 1024)};
    h[1] = {16'hbeef, 16'(id)};
    h[2] = is4 ? (32'hcafe0000 | 32'(id)) : {24'(id), 5'b0, a2, 2'b00};
    h[3] = {24'(id + 7), 5'b0, a2, 2'b00};
    if (dat) begin
      for (int k = 0; k < len; k++) begin
        pay.push_back(32'(id * 4096 + k) ^ 32'h5a000000);
        exp_dw.push_back(32'(id * 4096 + k) ^ 32'h5a000000);
        exp_last.push_back(k == len - 1);
        exp_tag.push_back(is4 ? "R4" : "R3");
      end
    end
    exp_hdr.push_back({is4, is4 ? {h[3], h[2], h[1], h[0]} : {32'b0, h[2], h[1], h[0]}});
    exp_hdr_dat.push_back(dat);
    b = {is4 ? h[3] : ((dat && a2) ? pay[0] : 32'hdeadbeef), h[2], h[1], h[0]};
    start = (!is4 && a2) ? 1 : 0;
    if (dat) begin
      if (is4 && a2) st.push_back(32'hbad0bad0);
      for (int k = start; k < len; k++) st.push_back(pay[k]);
    end
    bq_data.push_back(b);
    bq_sop.push_back(1'b1);
    bq_eop.push_back(st.size() == 0);
    bq_empty.push_back(1'b0);
    idx = 0;
    while (idx < st.size()) begin
      n = (st.size() - idx > 4) ? 4 : st.size() - idx;
      for (int l = 0; l < 4; l++)
        b[l*32 +: 32] = (l < n) ? st[idx + l] : (32'hf00d0000 | 32'(l));
      idx += n;
      bq_data.push_back(b);
      bq_sop.push_back(1'b0);
      bq_eop.push_back(idx == st.size());
      bq_empty.push_back((idx == st.size()) && n <= 2);
    end
  endtask

  task automatic take_out_beat();
    int c;
    bit seen_last;
    logic [31:0] d;
    bit l;
    string t;
    c = int'(out_cnt_o);
    seen_last = 0;
    chk(c >= 1 && c <= 4, "R6", "beat count range", 128'(c), 128'(4));
    for (int i = 0; i < c && i < 4; i++) begin
      if (exp_dw.size() == 0) begin
        chk(0, "R8", "payload beat with none expected", 128'(c), 128'(0));
        break;
      end
      d = exp_dw.pop_front();
      l = exp_last.pop_front();
      t = exp_tag.pop_front();
      chk(out_data_o[i*32 +: 32] === d, t, "payload dword in lane", out_data_o[i*32 +: 32], d);
      if (l) begin
        chk(i == c - 1, "R5", "dwords past packet end", 128'(c), 128'(i + 1));
        chk(out_last_o === 1'b1, "R7", "end flag on final beat", 128'(out_last_o), 128'(1));
        seen_last = 1;
        break;
      end
    end
    if (!seen_last) begin
      chk(out_last_o === 1'b0, "R7", "end flag on inner beat", 128'(out_last_o), 128'(0));
      chk(c == 4, "R6", "inner beat full", 128'(c), 128'(4));
    end
  endtask

  task automatic take_hdr();
    logic [128:0] e;
    bit dat;
    if (exp_hdr.size() == 0) begin
      chk(0, "R2", "unexpected header pulse", hdr_o, 128'(0));
      return;
    end
    e = exp_hdr.pop_front();
    dat = exp_hdr_dat.pop_front();
    chk(hdr_o === e[127:0], dat ? "R2" : "R8", "header dwords", hdr_o, e[127:0]);
    chk(hdr_4dw_o === e[128], "R1", "header size flag", 128'(hdr_4dw_o), 128'(e[128]));
  endtask

  task automatic run_mode(int mode);
    int guard;
    logic [15:0] lfsr;
    bit iv;
    guard = 0;
    lfsr = 16'hace1 ^ 16'(mode);
    while ((bq_data.size() > 0 || exp_dw.size() > 0 || exp_hdr.size() > 0) && guard < 40000) begin
      @(negedge clk_i);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: begin out_ready_i = 1'b1; iv = 1'b1; end
        1: begin out_ready_i = (guard % 3) != 0; iv = (guard % 2) == 0; end
        default: begin out_ready_i = lfsr[0] | lfsr[3]; iv = lfsr[5] | lfsr[8]; end
      endcase
      if (iv && bq_data.size() > 0) begin
        in_valid_i = 1'b1;
        in_data_i  = bq_data[0];
        in_sop_i   = bq_sop[0];
        in_eop_i   = bq_eop[0];
        in_empty_i = bq_empty[0];
      end else begin
        in_valid_i = 1'b0;
        in_sop_i   = 1'b0;
        in_eop_i   = 1'b0;
        in_empty_i = 1'b0;
      end
      #1;
      if (in_valid_i && in_ready_o) begin
        void'(bq_data.pop_front());
        void'(bq_sop.pop_front());
        void'(bq_eop.pop_front());
        void'(bq_empty.pop_front());
      end
      if (hdr_valid_o) take_hdr();
      if (out_valid_o && out_ready_i) take_out_beat();
    end
    in_valid_i = 1'b0;
    chk(exp_dw.size() == 0 && exp_hdr.size() == 0, "R9",
        $sformatf("all dwords and headers delivered, stall mode %0d", mode),
        128'(exp_dw.size() + exp_hdr.size()), 128'(0));
    repeat (4) @(negedge clk_i);
    #1;
    chk(out_valid_o === 1'b0, "R8", "no stray beat after drain", 128'(out_valid_o), 128'(0));
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int id;
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid_o === 1'b0, "R10", "out_valid in reset", 128'(out_valid_o), 128'(0));
    chk(hdr_valid_o === 1'b0, "R10", "hdr_valid in reset", 128'(hdr_valid_o), 128'(0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    id = 1;
    for (int mode = 0; mode < 3; mode++) begin
      for (int is4 = 0; is4 < 2; is4++)
        for (int a2 = 0; a2 < 2; a2++) begin
          add_pkt(is4[0], a2[0], 1'b0, 3, id); id++;
          for (int len = 1; len <= 12; len++) begin
            add_pkt(is4[0], a2[0], 1'b1, len, id); id++;
          end
        end
      if (mode == 0) begin
        add_pkt(1'b1, 1'b1, 1'b1, 1024, id); id++;   // R1 zero length field
      end
      run_mode(mode);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule